// File: doc/BRIEF.md
# Substrate clear pulse generator

This block drives the substrate clear (electronic shutter) outputs of an image sensor timing generator. It is fed by the horizontal pixel counter and by line and field markers, and it places one shutter pulse per line at programmed pixel positions. Pulsing begins only after the sensor gate line of the field, optionally after a programmed number of further quiet lines. It stops once a programmed number of pulsed lines has been produced.

On the final pulsed line a second, independently positioned pulse can be added for fine control of exposure length. A field-level enable from the exposure sequencer can hold the outputs at their idle level for whole lines. Every setting is written into a holding copy and becomes active only at the start of the line after the sensor gate line, so that a field never runs on a half-updated set of settings.

Top module: `subclr_pulse_gen`

## Requirements
- R1: After reset all outputs are low, and no pulse appears in a field until a sensor gate line has been followed by a further line.
- R2: A line that starts with `gate_line` high never carries a pulse. A `field_start` cycle clears the sequence and returns the outputs to the idle level; a `line_start` in the same cycle is ignored.
- R3: With a skip count S, numbering the line after the gate line as 1, lines 1 to S carry no pulse and line S+1 is the first line that may pulse. Skipped lines are counted whether or not the enable is high.
- R4: With a pulse count N, exactly the first N enabled, non-skipped lines after the gate line pulse; later lines of the field stay idle. N = 0 gives no pulse.
- R5: Each position setting holds the rising toggle in bits [PIX_W-1:0] and the falling toggle in bits [2*PIX_W-1:PIX_W]. The pulse level turns on at the clock edge where `pix_cnt` equals the rising toggle and off at the edge where it equals the falling toggle; it is cleared at each line start, and equal toggles give no pulse. Outputs follow with one register stage.
- R6: The second position pair adds its pulse, combined by OR with the normal one, only on the last of the N pulsed lines.
- R7: The polarity bit is the idle level of every output; the pulse drives the inverted level. All outputs carry the same waveform.
- R8: While `field_en` is low, the outputs are at the idle level from the next cycle on, and a line that starts with `field_en` low does not consume one of the N pulses.
- R9: Writes with `cfg_wr` land in a holding copy and have no effect on the outputs until the `line_start` of the line after a gate line; from that edge on, polarity, positions and counts come from the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_cnt | input | PIX_W | Pixel position within the line, 0 at line start |
| line_start | input | 1 | One-cycle marker of the first pixel of a line |
| field_start | input | 1 | One-cycle marker of a new field |
| gate_line | input | 1 | Sampled with `line_start`: this line is the sensor gate line |
| field_en | input | 1 | Field-level enable from the exposure sequencer |
| cfg_wr | input | 1 | Write strobe for the holding copy of the settings |
| cfg_pol | input | 1 | Idle level of the outputs |
| cfg_main_pos | input | 2*PIX_W | Toggle positions of the per-line pulse |
| cfg_fine_pos | input | 2*PIX_W | Toggle positions of the pulse on the last pulsed line |
| cfg_pulse_cnt | input | CNT_W | Pulsed lines per field |
| cfg_skip_lines | input | CNT_W | Extra quiet lines after the gate line |
| clr_o | output | NUM_OUT | Substrate clear outputs |

## Verification
The bench builds the block with PIX_W = 12, NUM_OUT = 2 and CNT_W = 4, so that the largest pulse count and skip count (15 each) fit within one field of 33 short lines of 40 pixels. Full-scale toggle positions are kept, while the narrow counters make the all-ones boundary of both counts, the zero-count field and the wrap of the decrementing counters cheap to reach. A behavioural line-number model is compared with both outputs on every cycle, alongside per-field counts of pulse edges.

// File: rtl/subclr_pkg.sv
package subclr_pkg;

  // What a cycle means to the line sequencer.
  typedef enum logic [2:0] {
    LK_NONE,    // inside a line
    LK_FIELD,   // field marker, clears the sequence
    LK_GATE,    // sensor gate line begins
    LK_RELOAD,  // first line after the gate line: settings load here
    LK_COUNT,   // later line of an armed field
    LK_OFF      // line before any gate line
  } line_kind_e;

  function automatic line_kind_e classify(input logic fs, input logic ls,
                                          input logic gl, input logic seen,
                                          input logic armed);
    if (fs)    return LK_FIELD;
    if (!ls)   return LK_NONE;
    if (gl)    return LK_GATE;
    if (seen)  return LK_RELOAD;
    if (armed) return LK_COUNT;
    return LK_OFF;
  endfunction

endpackage

// File: rtl/subclr_cfg.sv
module subclr_cfg #(
  parameter int PIX_W = 12,
  parameter int CNT_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_pol,
  input  logic [2*PIX_W-1:0]   cfg_main_pos,
  input  logic [2*PIX_W-1:0]   cfg_fine_pos,
  input  logic [CNT_W-1:0]     cfg_pulse_cnt,
  input  logic [CNT_W-1:0]     cfg_skip_lines,
  input  logic                 reload,
  output logic                 act_pol,
  output logic [2*PIX_W-1:0]   cur_main_pos,
  output logic [2*PIX_W-1:0]   cur_fine_pos,
  output logic [CNT_W-1:0]     cur_pulse_cnt,
  output logic [CNT_W-1:0]     cur_skip_lines
);
  localparam int POS_W = 2 * PIX_W;

  logic             hold_pol,  run_pol;
  logic [POS_W-1:0] hold_main, run_main, hold_fine, run_fine;
  logic [CNT_W-1:0] hold_cnt,  run_cnt,  hold_skip, run_skip;

  // Holding copy: written at any time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_pol <= 1'b0; hold_main <= '0; hold_fine <= '0;
      hold_cnt <= '0;   hold_skip <= '0;
    end else if (cfg_wr) begin
      hold_pol <= cfg_pol;        hold_main <= cfg_main_pos;
      hold_fine <= cfg_fine_pos;  hold_cnt  <= cfg_pulse_cnt;
      hold_skip <= cfg_skip_lines;
    end
  end

  // Running copy: loaded only on the line after the gate line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_pol <= 1'b0; run_main <= '0; run_fine <= '0;
      run_cnt <= '0;   run_skip <= '0;
    end else if (reload) begin
      run_pol <= hold_pol;   run_main <= hold_main;
      run_fine <= hold_fine; run_cnt  <= hold_cnt;
      run_skip <= hold_skip;
    end
  end

  // The reload line already uses the new values in its first cycle.
  assign act_pol        = run_pol;
  assign cur_main_pos   = reload ? hold_main : run_main;
  assign cur_fine_pos   = reload ? hold_fine : run_fine;
  assign cur_pulse_cnt  = reload ? hold_cnt  : run_cnt;
  assign cur_skip_lines = reload ? hold_skip : run_skip;

  p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable({run_pol, run_main, run_fine, run_cnt, run_skip}));

endmodule

// File: rtl/subclr_line_seq.sv
module subclr_line_seq
  import subclr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic             line_start,
  input  logic             gate_line,
  input  logic             field_en,
  input  logic [CNT_W-1:0] cur_pulse_cnt,
  input  logic [CNT_W-1:0] cur_skip_lines,
  output logic             reload,
  output logic             line_evt,
  output logic             on_now,
  output logic             last_now
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             gate_seen, armed, on_q, last_q;
  logic [CNT_W-1:0] wait_q, left_q, wait_v, left_v;
  line_kind_e       kind;
  logic             count_line, hold, fire;

  assign kind       = classify(field_start, line_start, gate_line, gate_seen, armed);
  assign reload     = (kind == LK_RELOAD);
  assign line_evt   = (kind != LK_NONE);
  assign count_line = (kind == LK_RELOAD) || (kind == LK_COUNT);
  assign wait_v     = reload ? cur_skip_lines : wait_q;
  assign left_v     = reload ? cur_pulse_cnt  : left_q;
  assign hold       = (wait_v != '0);
  assign fire       = count_line && !hold && (left_v != '0) && field_en;

  assign on_now   = line_evt ? fire : (on_q && field_en);
  assign last_now = line_evt ? (fire && left_v == CNT_ONE) : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_seen <= 1'b0; armed <= 1'b0; on_q <= 1'b0; last_q <= 1'b0;
      wait_q <= '0; left_q <= '0;
    end else begin
      unique case (kind)
        LK_FIELD: begin
          gate_seen <= 1'b0; armed <= 1'b0; on_q <= 1'b0; last_q <= 1'b0;
        end
        LK_GATE: begin
          gate_seen <= 1'b1; on_q <= 1'b0; last_q <= 1'b0;
        end
        LK_OFF: begin
          on_q <= 1'b0; last_q <= 1'b0;
        end
        LK_RELOAD, LK_COUNT: begin
          if (reload) begin
            gate_seen <= 1'b0; armed <= 1'b1;
          end
          wait_q <= hold ? (wait_v - CNT_ONE) : wait_v;
          left_q <= fire ? (left_v - CNT_ONE) : left_v;
          on_q   <= fire;
          last_q <= fire && (left_v == CNT_ONE);
        end
        default: ;
      endcase
    end
  end

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_OFF) |=> !on_q);
  p_gate_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_GATE || kind == LK_FIELD) |=> !on_q);
  p_skip_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_COUNT && wait_q != '0) |=> !on_q);
  p_count_spent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_COUNT && left_q == '0) |=> !on_q);
  p_last_is_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> on_q);

endmodule

// File: rtl/subclr_toggle.sv
module subclr_toggle #(
  parameter int PIX_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIX_W-1:0]   pix_i,
  input  logic [2*PIX_W-1:0] pos_i,
  input  logic               restart,
  input  logic               run,
  output logic               lvl_q
);
  logic [PIX_W-1:0] rise_at, fall_at;
  logic             lvl_n;

  assign rise_at = pos_i[PIX_W-1:0];
  assign fall_at = pos_i[2*PIX_W-1:PIX_W];

  // One pixel step of the toggle pair; equal positions never pulse.
  function automatic logic step(input logic from, input logic [PIX_W-1:0] p,
                                input logic [PIX_W-1:0] up,
                                input logic [PIX_W-1:0] dn);
    if (up == dn) return 1'b0;
    if (p == up)  return 1'b1;
    if (p == dn)  return 1'b0;
    return from;
  endfunction

  assign lvl_n = run ? step(restart ? 1'b0 : lvl_q, pix_i, rise_at, fall_at) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_n;
  end

  p_equal_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_at == fall_at) |=> !lvl_q);
  p_rise_at_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(pix_i == rise_at));

endmodule

// File: rtl/subclr_pulse_gen.sv
module subclr_pulse_gen #(
  parameter int PIX_W   = 12,
  parameter int CNT_W   = 12,
  parameter int NUM_OUT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIX_W-1:0]     pix_cnt,
  input  logic                 line_start,
  input  logic                 field_start,
  input  logic                 gate_line,
  input  logic                 field_en,
  input  logic                 cfg_wr,
  input  logic                 cfg_pol,
  input  logic [2*PIX_W-1:0]   cfg_main_pos,
  input  logic [2*PIX_W-1:0]   cfg_fine_pos,
  input  logic [CNT_W-1:0]     cfg_pulse_cnt,
  input  logic [CNT_W-1:0]     cfg_skip_lines,
  output logic [NUM_OUT-1:0]   clr_o
);
  localparam int POS_W = 2 * PIX_W;

  logic             reload, line_evt, on_now, last_now, act_pol;
  logic [POS_W-1:0] cur_main_pos, cur_fine_pos;
  logic [CNT_W-1:0] cur_pulse_cnt, cur_skip_lines;
  logic             lvl_main, lvl_fine;

  subclr_cfg #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pol(cfg_pol),
    .cfg_main_pos(cfg_main_pos), .cfg_fine_pos(cfg_fine_pos),
    .cfg_pulse_cnt(cfg_pulse_cnt), .cfg_skip_lines(cfg_skip_lines),
    .reload(reload), .act_pol(act_pol),
    .cur_main_pos(cur_main_pos), .cur_fine_pos(cur_fine_pos),
    .cur_pulse_cnt(cur_pulse_cnt), .cur_skip_lines(cur_skip_lines)
  );

  subclr_line_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .field_start(field_start),
    .line_start(line_start), .gate_line(gate_line), .field_en(field_en),
    .cur_pulse_cnt(cur_pulse_cnt), .cur_skip_lines(cur_skip_lines),
    .reload(reload), .line_evt(line_evt), .on_now(on_now), .last_now(last_now)
  );

  subclr_toggle #(.PIX_W(PIX_W)) u_main (
    .clk(clk), .rst_n(rst_n), .pix_i(pix_cnt), .pos_i(cur_main_pos),
    .restart(line_evt), .run(on_now), .lvl_q(lvl_main)
  );

  subclr_toggle #(.PIX_W(PIX_W)) u_fine (
    .clk(clk), .rst_n(rst_n), .pix_i(pix_cnt), .pos_i(cur_fine_pos),
    .restart(line_evt), .run(on_now && last_now), .lvl_q(lvl_fine)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign clr_o[g] = act_pol ^ (lvl_main | lvl_fine);
  end

  p_idle_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !field_en |=> (clr_o == {NUM_OUT{act_pol}}));
  p_field_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (clr_o == {NUM_OUT{act_pol}}));
  p_fine_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_fine && !line_evt) |-> last_now);

endmodule

// File: tb/subclr_pulse_gen_bench.sv
module subclr_pulse_gen_bench;
  localparam int PIX_W = 12;
  localparam int CNT_W = 4;
  localparam int NOUT  = 2;
  localparam int LINE_LEN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PIX_W-1:0] pix_cnt = '0;
  logic line_start = 1'b0, field_start = 1'b0, gate_line = 1'b0, field_en = 1'b1;
  logic cfg_wr = 1'b0, cfg_pol = 1'b0;
  logic [2*PIX_W-1:0] cfg_main_pos = '0, cfg_fine_pos = '0;
  logic [CNT_W-1:0] cfg_pulse_cnt = '0, cfg_skip_lines = '0;
  logic [NOUT-1:0] clr_o;

  always #2.5 clk = ~clk;

  subclr_pulse_gen #(.PIX_W(PIX_W), .CNT_W(CNT_W), .NUM_OUT(NOUT)) u_subclr_pulse_gen (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_start(line_start),
    .field_start(field_start), .gate_line(gate_line), .field_en(field_en),
    .cfg_wr(cfg_wr), .cfg_pol(cfg_pol), .cfg_main_pos(cfg_main_pos),
    .cfg_fine_pos(cfg_fine_pos), .cfg_pulse_cnt(cfg_pulse_cnt),
    .cfg_skip_lines(cfg_skip_lines), .clr_o(clr_o)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  // Reference model state: line numbers and pulse tallies.
  int s_pol, s_a1, s_b1, s_a2, s_b2, s_num, s_skip;
  int m_pol, m_a1, m_b1, m_a2, m_b2, m_num, m_skip;
  bit m_gate, m_on, m_last, m_exp;
  int m_idx, m_done;
  int edges; bit tb_idle; logic prev_o;

  function automatic bit win(int a, int b, int p);
    return (a != b) && (p >= a) && ((a > b) || (p < b));
  endfunction

  task automatic check(string req, logic [NOUT-1:0] got, logic [NOUT-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: clr_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_int(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic decide();
    m_on   = field_en && (m_idx > m_skip) && (m_done < m_num);
    m_last = m_on && (m_done == m_num - 1);
    if (m_on) m_done++;
  endtask

  // One clock: advance the model with the present inputs, then compare.
  task automatic cyc();
    if (!rst_n) begin
      s_pol = 0; s_a1 = 0; s_b1 = 0; s_a2 = 0; s_b2 = 0; s_num = 0; s_skip = 0;
      m_pol = 0; m_a1 = 0; m_b1 = 0; m_a2 = 0; m_b2 = 0; m_num = 0; m_skip = 0;
      m_gate = 0; m_on = 0; m_last = 0; m_idx = 0; m_done = 0; m_exp = 0;
    end else begin
      if (field_start) begin
        m_gate = 0; m_idx = 0; m_on = 0; m_last = 0;
      end else if (line_start) begin
        if (gate_line) begin
          m_gate = 1; m_on = 0; m_last = 0;
        end else if (m_gate) begin
          m_pol = s_pol; m_a1 = s_a1; m_b1 = s_b1; m_a2 = s_a2; m_b2 = s_b2;
          m_num = s_num; m_skip = s_skip;
          m_gate = 0; m_idx = 1; m_done = 0;
          decide();
        end else if (m_idx > 0) begin
          m_idx++;
          decide();
        end else begin
          m_on = 0; m_last = 0;
        end
      end
      m_exp = m_pol[0] ^ (field_en && m_on &&
              (win(m_a1, m_b1, int'(pix_cnt)) || (m_last && win(m_a2, m_b2, int'(pix_cnt)))));
      if (cfg_wr) begin
        s_pol = int'(cfg_pol);
        s_a1 = int'(cfg_main_pos[PIX_W-1:0]); s_b1 = int'(cfg_main_pos[2*PIX_W-1:PIX_W]);
        s_a2 = int'(cfg_fine_pos[PIX_W-1:0]); s_b2 = int'(cfg_fine_pos[2*PIX_W-1:PIX_W]);
        s_num = int'(cfg_pulse_cnt); s_skip = int'(cfg_skip_lines);
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(cur_req, clr_o, {NOUT{m_exp}});
    if (prev_o === tb_idle && clr_o[0] !== tb_idle) edges++;
    prev_o = clr_o[0];
  endtask

  task automatic set_cfg(bit pol, int a1, int b1, int a2, int b2, int num, int skip);
    cfg_pol = pol;
    cfg_main_pos = {PIX_W'(b1), PIX_W'(a1)};
    cfg_fine_pos = {PIX_W'(b2), PIX_W'(a2)};
    cfg_pulse_cnt = CNT_W'(num);
    cfg_skip_lines = CNT_W'(skip);
  endtask

  // Write the holding copy in a field marker cycle.
  task automatic write_cfg(bit pol, int a1, int b1, int a2, int b2, int num, int skip);
    set_cfg(pol, a1, b1, a2, b2, num, skip);
    field_start = 1'b1; cfg_wr = 1'b1; pix_cnt = '0;
    cyc();
    field_start = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic run_field(int nlines, int gate_at, int off_line, int wr_line);
    edges = 0;
    field_start = 1'b1; pix_cnt = '0;
    cyc();
    field_start = 1'b0;
    for (int i = 0; i < nlines; i++) begin
      field_en = (i != off_line);
      for (int p = 0; p < LINE_LEN; p++) begin
        line_start = (p == 0);
        gate_line  = (p == 0) && (i == gate_at);
        cfg_wr     = (i == wr_line) && (p == 5);
        pix_cnt    = PIX_W'(p);
        cyc();
      end
    end
    line_start = 1'b0; gate_line = 1'b0; cfg_wr = 1'b0; field_en = 1'b1;
  endtask

  initial begin
    tb_idle = 1'b0; prev_o = 1'b0; edges = 0;
    cur_req = "R1";
    repeat (3) cyc();
    rst_n = 1'b1;
    check("R1 reset level", clr_o, '0);
    // No gate line yet: the field stays quiet (R1).
    write_cfg(0, 5, 10, 20, 25, 3, 0);
    run_field(3, -1, -1, -1);
    check_int("R1 no pulse before gate", edges, 0);

    // Normal pulses plus the fine pulse on the last line (R2 R4 R5 R6).
    cur_req = "R4/R6";
    run_field(8, 1, -1, -1);
    check_int("R4 three lines plus R6 fine pulse", edges, 4);

    // Skip count delays the first pulse (R3).
    cur_req = "R3";
    write_cfg(0, 5, 10, 20, 25, 4, 2);
    run_field(10, 0, -1, -1);
    check_int("R3 skip two lines then four pulses", edges, 5);

    // Disabled line does not consume a pulse (R8).
    cur_req = "R8";
    write_cfg(0, 5, 10, 20, 25, 3, 1);
    run_field(8, 0, 3, -1);
    check_int("R8 disabled line not counted", edges, 4);

    // Equal main positions: only the fine pulse remains (R5 R6).
    cur_req = "R5";
    write_cfg(0, 7, 7, 12, 18, 2, 0);
    run_field(5, 0, -1, -1);
    check_int("R5 equal toggles give no pulse", edges, 1);

    // Rising toggle after falling toggle: pulse to line end (R5).
    write_cfg(0, 30, 8, 0, 0, 2, 0);
    run_field(5, 0, -1, -1);
    check_int("R5 late rising toggle", edges, 2);

    // Inverted polarity (R7).
    cur_req = "R7";
    write_cfg(1, 5, 10, 0, 0, 2, 0);
    tb_idle = 1'b1;
    run_field(4, 0, -1, -1);
    check_int("R7 pulses with high idle level", edges, 2);
    check("R7 idle high on both outputs", clr_o, 2'b11);

    // Largest counts (R3 R4).
    cur_req = "R3/R4";
    write_cfg(1, 5, 10, 20, 25, 15, 15);
    run_field(33, 0, -1, -1);
    check_int("R4 fifteen pulses after R3 fifteen skipped lines", edges, 16);

    // Zero pulse count (R4).
    write_cfg(1, 5, 10, 20, 25, 0, 0);
    run_field(5, 0, -1, -1);
    check_int("R4 zero count gives no pulse", edges, 0);

    // Write mid-field, applied only after the gate line (R9).
    cur_req = "R9";
    set_cfg(0, 5, 10, 0, 0, 1, 0);
    run_field(6, 3, -1, 1);
    check("R9 new idle level after reload line", clr_o, 2'b00);
    // Holding copy written with no gate line: running values stay (R9 R2).
    write_cfg(1, 5, 10, 0, 0, 1, 0);
    run_field(3, -1, -1, -1);
    check("R9 write without gate has no effect", clr_o, 2'b00);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule